// File: doc/BRIEF.md
# Integer Execute Stage for a Three-Format 32-bit Instruction Set

This block is the combinational execute step of a simple 32-bit processor. In one evaluation it takes a fetched instruction word, the address that word came from, and the two source register values already read from the register file. From these it produces a register write (enable, index and data), the address of the next instruction, and two flags. Instruction words come in three layouts: register, immediate and jump.

The block carries out these instruction groups:

- shifts by a constant amount;
- bitwise logic;
- wrapping add and subtract, which never trap;
- signed and unsigned less-than compares;
- the immediate forms of the above, and upper-half immediate loads;
- absolute jumps, register jumps (both with an optional link);
- compare-and-branch, with no delay slot.

Multiplies, high/low result moves, memory loads and stores, and the system call are not carried out here. They are recognised and passed on through a hand-off flag. Any other encoding raises an illegal flag and leaves the program counter where it was. The register file and instruction memory sit outside the block. The surrounding machine starts at address 0x00001000 with every register cleared.

Top module: `exec_unit`

## Requirements
- R1: Fields are taken MSB first as opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0], imm[15:0], target[25:0]. Register-layout results go to rd and immediate-layout results go to rt.
- R2: With opcode 0x00, funct 0x00/0x02/0x03 shift the rt value left, right logical and right arithmetic by shamt, writing the result to rd.
- R3: Funct 0x21 adds rs+rt and funct 0x23 subtracts rs-rt, both modulo 2^32 and without any fault.
- R4: Funct 0x24/0x25/0x26/0x27 give AND, OR, XOR and NOR of rs and rt.
- R5: Funct 0x2a writes 1 when rs<rt as signed values, and funct 0x2b writes 1 when rs<rt as unsigned values; otherwise each writes 0.
- R6: Opcodes 0x09 (add), 0x0a (signed less-than) and 0x0b (unsigned less-than) sign-extend imm. 0x0b compares unsigned against the sign-extended value.
- R7: Opcodes 0x0c/0x0d/0x0e (AND/OR/XOR) zero-extend imm. Opcode 0x0f writes imm into the upper half of rt with the lower half zero.
- R8: Opcodes 0x02 and 0x03 jump to {bits 31:28 of PC+4, target, 2'b00}. Opcode 0x03 also writes PC+4 to register 31.
- R9: Funct 0x08 jumps to the rs value. Funct 0x09 also writes PC+4 to rd, and the link value is PC+4 even when rd equals rs.
- R10: Opcode 0x04 (equal) and 0x05 (not equal) go to PC+4+sext(imm)*4 when their condition holds and to PC+4 otherwise, with no delay slot.
- R11: No write is ever requested to register 0.
- R12: Funct 0x0c/0x10/0x12/0x18/0x19 and opcodes 0x20/0x21/0x23/0x24/0x25/0x28/0x29/0x2b raise the hand-off flag, request no write, and advance to PC+4.
- R13: Any other encoding, or a register jump to an address whose two low bits are not both zero, raises the illegal flag, requests no write, and leaves the next PC equal to PC.
- R14: Every legal instruction other than a jump or a taken branch advances to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Fetched instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs_val_i | input | 32 | Value of the register named by rs |
| rt_val_i | input | 32 | Value of the register named by rt |
| wr_en_o | output | 1 | Register write request |
| wr_idx_o | output | 5 | Register index to write |
| wr_data_o | output | 32 | Value to write |
| pc_next_o | output | 32 | Address of the next instruction |
| illegal_o | output | 1 | Unsupported encoding or misaligned register jump |
| offload_o | output | 1 | Instruction belongs to another unit |

## Verification
Three cases are the hardest to reach, because ordinary addresses hide the mistakes they would expose.

- **Jump-target region bits.** These come from PC+4, not PC, and the two differ only when the instruction sits in the last word before a 256 MB boundary. The stimulus places a jump at 0x0FFFFFFC to check this.
- **Link with rd equal to rs.** A register jump that links into its own source register must still write PC+4. The stimulus uses this aliasing, with a jump value that differs clearly from the link value.
- **Unsigned compare against a negative immediate.** This only shows a difference when the immediate has bit 15 set. The stimulus picks such an immediate.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int XLEN     = 32;
    localparam int REG_AW   = 5;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int INSN_BYTES = 4;
    localparam logic [REG_AW-1:0] LINK_REG = 5'd31;

    // primary opcodes
    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_JMP   = 6'h02;
    localparam logic [5:0] OPC_JLNK  = 6'h03;
    localparam logic [5:0] OPC_BREQ  = 6'h04;
    localparam logic [5:0] OPC_BRNE  = 6'h05;
    localparam logic [5:0] OPC_ADDI  = 6'h09;
    localparam logic [5:0] OPC_LTI   = 6'h0a;
    localparam logic [5:0] OPC_LTIU  = 6'h0b;
    localparam logic [5:0] OPC_ANDI  = 6'h0c;
    localparam logic [5:0] OPC_ORI   = 6'h0d;
    localparam logic [5:0] OPC_XORI  = 6'h0e;
    localparam logic [5:0] OPC_UPI   = 6'h0f;

    typedef enum logic [3:0] {
        ALU_SHL, ALU_SHR, ALU_SAR, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR,
        ALU_XOR, ALU_NOR, ALU_LT, ALU_LTU, ALU_UPPER, ALU_LINK
    } alu_op_e;

    typedef enum logic [1:0] { SRC_REG, SRC_SEXT, SRC_ZEXT } bsrc_e;
    typedef enum logic [1:0] { DST_NONE, DST_RD, DST_RT, DST_LINK } dst_e;
    typedef enum logic [2:0] {
        NPC_SEQ, NPC_ABS, NPC_REG, NPC_BEQ, NPC_BNE, NPC_HOLD
    } npc_e;

    typedef struct packed {
        alu_op_e alu_op;
        bsrc_e   bsrc;
        dst_e    dst;
        npc_e    npc;
        logic    illegal;
        logic    offload;
    } ctrl_t;
endpackage

// File: rtl/exec_decode.sv
module exec_decode
    import exec_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output ctrl_t      ctrl_o
);
    always_comb begin
        ctrl_o = '{alu_op: ALU_ADD, bsrc: SRC_REG, dst: DST_NONE,
                   npc: NPC_SEQ, illegal: 1'b0, offload: 1'b0};
        unique case (opcode_i)
            OPC_REG: begin
                ctrl_o.dst = DST_RD;
                unique case (funct_i)
                    6'h00: ctrl_o.alu_op = ALU_SHL;
                    6'h02: ctrl_o.alu_op = ALU_SHR;
                    6'h03: ctrl_o.alu_op = ALU_SAR;
                    6'h08: begin ctrl_o.dst = DST_NONE; ctrl_o.npc = NPC_REG; end
                    6'h09: begin ctrl_o.alu_op = ALU_LINK; ctrl_o.npc = NPC_REG; end
                    6'h21: ctrl_o.alu_op = ALU_ADD;
                    6'h23: ctrl_o.alu_op = ALU_SUB;
                    6'h24: ctrl_o.alu_op = ALU_AND;
                    6'h25: ctrl_o.alu_op = ALU_OR;
                    6'h26: ctrl_o.alu_op = ALU_XOR;
                    6'h27: ctrl_o.alu_op = ALU_NOR;
                    6'h2a: ctrl_o.alu_op = ALU_LT;
                    6'h2b: ctrl_o.alu_op = ALU_LTU;
                    6'h0c, 6'h10, 6'h12, 6'h18, 6'h19: begin
                        ctrl_o.dst     = DST_NONE;
                        ctrl_o.offload = 1'b1;
                    end
                    default: begin
                        ctrl_o.dst     = DST_NONE;
                        ctrl_o.npc     = NPC_HOLD;
                        ctrl_o.illegal = 1'b1;
                    end
                endcase
            end
            OPC_JMP:  ctrl_o.npc = NPC_ABS;
            OPC_JLNK: begin
                ctrl_o.npc    = NPC_ABS;
                ctrl_o.dst    = DST_LINK;
                ctrl_o.alu_op = ALU_LINK;
            end
            OPC_BREQ: ctrl_o.npc = NPC_BEQ;
            OPC_BRNE: ctrl_o.npc = NPC_BNE;
            OPC_ADDI: begin ctrl_o.dst = DST_RT; ctrl_o.bsrc = SRC_SEXT; ctrl_o.alu_op = ALU_ADD; end
            OPC_LTI:  begin ctrl_o.dst = DST_RT; ctrl_o.bsrc = SRC_SEXT; ctrl_o.alu_op = ALU_LT; end
            OPC_LTIU: begin ctrl_o.dst = DST_RT; ctrl_o.bsrc = SRC_SEXT; ctrl_o.alu_op = ALU_LTU; end
            OPC_ANDI: begin ctrl_o.dst = DST_RT; ctrl_o.bsrc = SRC_ZEXT; ctrl_o.alu_op = ALU_AND; end
            OPC_ORI:  begin ctrl_o.dst = DST_RT; ctrl_o.bsrc = SRC_ZEXT; ctrl_o.alu_op = ALU_OR; end
            OPC_XORI: begin ctrl_o.dst = DST_RT; ctrl_o.bsrc = SRC_ZEXT; ctrl_o.alu_op = ALU_XOR; end
            OPC_UPI:  begin ctrl_o.dst = DST_RT; ctrl_o.bsrc = SRC_ZEXT; ctrl_o.alu_op = ALU_UPPER; end
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2b:
                ctrl_o.offload = 1'b1;
            default: begin
                ctrl_o.npc     = NPC_HOLD;
                ctrl_o.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int SH_W = $clog2(W),
    parameter int HALF = W / 2
) (
    input  alu_op_e         op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [SH_W-1:0] shamt_i,
    input  logic [W-1:0]    link_i,
    output logic [W-1:0]    y_o
);
    always_comb begin
        unique case (op_i)
            ALU_SHL:   y_o = b_i << shamt_i;
            ALU_SHR:   y_o = b_i >> shamt_i;
            ALU_SAR:   y_o = W'($signed(b_i) >>> shamt_i);
            ALU_ADD:   y_o = a_i + b_i;
            ALU_SUB:   y_o = a_i - b_i;
            ALU_AND:   y_o = a_i & b_i;
            ALU_OR:    y_o = a_i | b_i;
            ALU_XOR:   y_o = a_i ^ b_i;
            ALU_NOR:   y_o = ~(a_i | b_i);
            ALU_LT:    y_o = W'($signed(a_i) < $signed(b_i));
            ALU_LTU:   y_o = W'(a_i < b_i);
            ALU_UPPER: y_o = {b_i[HALF-1:0], {HALF{1'b0}}};
            ALU_LINK:  y_o = link_i;
            default:   y_o = '0;
        endcase
    end
endmodule

// File: rtl/exec_npc.sv
module exec_npc
    import exec_pkg::*;
#(
    parameter int W      = XLEN,
    parameter int TW     = TGT_W,
    parameter int REGION = W - TW - 2
) (
    input  npc_e          sel_i,
    input  logic [W-1:0]  pc_i,
    input  logic [W-1:0]  pc4_i,
    input  logic [W-1:0]  rs_i,
    input  logic [W-1:0]  rt_i,
    input  logic [W-1:0]  simm_i,
    input  logic [TW-1:0] tgt_i,
    output logic [W-1:0]  npc_o,
    output logic          misalign_o
);
    logic [W-1:0] br_tgt;
    assign br_tgt = pc4_i + (simm_i << 2);

    always_comb begin
        misalign_o = 1'b0;
        unique case (sel_i)
            NPC_SEQ:  npc_o = pc4_i;
            NPC_ABS:  npc_o = {pc4_i[W-1 -: REGION], tgt_i, 2'b00};
            NPC_REG: begin
                misalign_o = (rs_i[1:0] != 2'b00);
                npc_o      = misalign_o ? pc_i : rs_i;
            end
            NPC_BEQ:  npc_o = (rs_i == rt_i) ? br_tgt : pc4_i;
            NPC_BNE:  npc_o = (rs_i != rt_i) ? br_tgt : pc4_i;
            default:  npc_o = pc_i;
        endcase
    end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
    import exec_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic        wr_en_o,
    output logic [4:0]  wr_idx_o,
    output logic [31:0] wr_data_o,
    output logic [31:0] pc_next_o,
    output logic        illegal_o,
    output logic        offload_o
);
    localparam int SH_W = $clog2(XLEN);

    ctrl_t              ctrl;
    logic [XLEN-1:0]    pc4, simm, zimm, opb, alu_y;
    logic               misalign;
    logic [REG_AW-1:0]  rd_f, rt_f;

    assign rd_f = insn_i[15:11];
    assign rt_f = insn_i[20:16];
    assign pc4  = pc_i + XLEN'(INSN_BYTES);
    assign simm = {{(XLEN-IMM_W){insn_i[IMM_W-1]}}, insn_i[IMM_W-1:0]};
    assign zimm = {{(XLEN-IMM_W){1'b0}}, insn_i[IMM_W-1:0]};

    exec_decode u_dec (
        .opcode_i (insn_i[31:26]),
        .funct_i  (insn_i[5:0]),
        .ctrl_o   (ctrl)
    );

    always_comb begin
        unique case (ctrl.bsrc)
            SRC_SEXT: opb = simm;
            SRC_ZEXT: opb = zimm;
            default:  opb = rt_val_i;
        endcase
    end

    exec_alu u_alu (
        .op_i    (ctrl.alu_op),
        .a_i     (rs_val_i),
        .b_i     (opb),
        .shamt_i (insn_i[6 +: SH_W]),
        .link_i  (pc4),
        .y_o     (alu_y)
    );

    exec_npc u_npc (
        .sel_i      (ctrl.npc),
        .pc_i       (pc_i),
        .pc4_i      (pc4),
        .rs_i       (rs_val_i),
        .rt_i       (rt_val_i),
        .simm_i     (simm),
        .tgt_i      (insn_i[TGT_W-1:0]),
        .npc_o      (pc_next_o),
        .misalign_o (misalign)
    );

    always_comb begin
        unique case (ctrl.dst)
            DST_RD:   wr_idx_o = rd_f;
            DST_RT:   wr_idx_o = rt_f;
            DST_LINK: wr_idx_o = LINK_REG;
            default:  wr_idx_o = '0;
        endcase
    end

    assign illegal_o = ctrl.illegal | misalign;
    assign offload_o = ctrl.offload;
    assign wr_data_o = alu_y;
    assign wr_en_o   = (ctrl.dst != DST_NONE) && (wr_idx_o != '0) && !illegal_o;
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk (
    input logic [31:0] insn_i,
    input logic [31:0] pc_i,
    input logic [31:0] rs_val_i,
    input logic [31:0] rt_val_i,
    input logic        wr_en_o,
    input logic [4:0]  wr_idx_o,
    input logic [31:0] wr_data_o,
    input logic [31:0] pc_next_o,
    input logic        illegal_o,
    input logic        offload_o
);
    always_comb begin
        AST_NO_ZERO_WRITE: assert (!(wr_en_o && wr_idx_o == 5'd0)); // R11
        AST_ILLEGAL_HOLD: assert (!illegal_o || (pc_next_o == pc_i && !wr_en_o)); // R13
        AST_OFFLOAD_STEP: assert (!offload_o || (!wr_en_o && !illegal_o && pc_next_o == pc_i + 32'd4)); // R12
        AST_LINK_VALUE: assert (!(insn_i[31:26] == 6'h03) || (wr_en_o && wr_idx_o == 5'd31 && wr_data_o == pc_i + 32'd4)); // R8
        AST_ALIGNED_NEXT: assert (illegal_o || pc_i[1:0] != 2'b00 || pc_next_o[1:0] == 2'b00); // R9
        AST_BRANCH_EQ: assert (!(insn_i[31:26] == 6'h04 && rs_val_i != rt_val_i) || pc_next_o == pc_i + 32'd4); // R10
    end
endmodule

bind exec_unit exec_unit_chk u_chk (
    .insn_i    (insn_i),
    .pc_i      (pc_i),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .wr_en_o   (wr_en_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o),
    .pc_next_o (pc_next_o),
    .illegal_o (illegal_o),
    .offload_o (offload_o)
);

// File: tb/tb_exec_unit.sv
module tb_exec_unit;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] insn, pc, rsv, rtv;
    logic        wr_en, ill, off;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data, npc;

    exec_unit dut (
        .insn_i(insn), .pc_i(pc), .rs_val_i(rsv), .rt_val_i(rtv),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
        .pc_next_o(npc), .illegal_o(ill), .offload_o(off)
    );

    typedef struct {
        string       tag;
        bit          we;
        logic [4:0]  idx;
        logic [31:0] data;
        logic [31:0] npc;
        bit          ill;
        bit          off;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    function automatic logic [31:0] rf(logic [4:0] s, logic [4:0] t, logic [4:0] d, logic [4:0] sh, logic [5:0] fn);
        return {6'h00, s, t, d, sh, fn};
    endfunction
    function automatic logic [31:0] imf(logic [5:0] op, logic [4:0] s, logic [4:0] t, logic [15:0] im);
        return {op, s, t, im};
    endfunction
    function automatic logic [31:0] jf(logic [5:0] op, logic [25:0] a);
        return {op, a};
    endfunction

    task automatic drive(string tag, logic [31:0] i, logic [31:0] p, logic [31:0] a, logic [31:0] b,
                         bit we, logic [4:0] idx, logic [31:0] data, logic [31:0] np, bit il, bit of);
        exp_t e;
        @(posedge clk);
        insn = i; pc = p; rsv = a; rtv = b;
        e.tag = tag; e.we = we; e.idx = idx; e.data = data; e.npc = np; e.ill = il; e.off = of;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (wr_en !== e.we || npc !== e.npc || ill !== e.ill || off !== e.off ||
                (e.we && (wr_idx !== e.idx || wr_data !== e.data))) begin
                bad++;
                $display("FAIL %s: got we=%0b idx=%0d data=%h npc=%h ill=%0b off=%0b exp we=%0b idx=%0d data=%h npc=%h ill=%0b off=%0b",
                         e.tag, wr_en, wr_idx, wr_data, npc, ill, off, e.we, e.idx, e.data, e.npc, e.ill, e.off);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        insn = 32'h0; pc = 32'h1000; rsv = 0; rtv = 0;
        // start state: all-zero word at the start address, no write (R11, R14)
        drive("R11 start nop", 32'h0, 32'h1000, 0, 0, 0, 0, 0, 32'h1004, 0, 0);
        // R3 wrapping arithmetic, R1 rd placement
        drive("R3 add wrap", rf(1,2,3,0,6'h21), 32'h1000, 32'hFFFFFFFF, 32'h2, 1, 3, 32'h1, 32'h1004, 0, 0);
        drive("R3 sub wrap", rf(1,2,7,0,6'h23), 32'h1004, 32'h0, 32'h1, 1, 7, 32'hFFFFFFFF, 32'h1008, 0, 0);
        // R2 shifts
        drive("R2 shl", rf(0,4,5,4,6'h00), 32'h1000, 0, 32'h80000001, 1, 5, 32'h00000010, 32'h1004, 0, 0);
        drive("R2 shr", rf(0,4,5,4,6'h02), 32'h1000, 0, 32'h80000000, 1, 5, 32'h08000000, 32'h1004, 0, 0);
        drive("R2 sar", rf(0,4,5,4,6'h03), 32'h1000, 0, 32'h80000000, 1, 5, 32'hF8000000, 32'h1004, 0, 0);
        // R4 logic
        drive("R4 and", rf(1,2,9,0,6'h24), 32'h1000, 32'hF0F01234, 32'h0FF0FF00, 1, 9, 32'h00F01200, 32'h1004, 0, 0);
        drive("R4 or",  rf(1,2,9,0,6'h25), 32'h1000, 32'hF0F01234, 32'h0FF0FF00, 1, 9, 32'hFFF0FF34, 32'h1004, 0, 0);
        drive("R4 xor", rf(1,2,9,0,6'h26), 32'h1000, 32'hF0F01234, 32'h0FF0FF00, 1, 9, 32'hFF00ED34, 32'h1004, 0, 0);
        drive("R4 nor", rf(1,2,9,0,6'h27), 32'h1000, 32'hF0F01234, 32'h0FF0FF00, 1, 9, 32'h000F00CB, 32'h1004, 0, 0);
        // R5 compares
        drive("R5 lt signed",   rf(1,2,10,0,6'h2a), 32'h1000, 32'hFFFFFFFF, 32'h1, 1, 10, 32'h1, 32'h1004, 0, 0);
        drive("R5 lt unsigned", rf(1,2,10,0,6'h2b), 32'h1000, 32'hFFFFFFFF, 32'h1, 1, 10, 32'h0, 32'h1004, 0, 0);
        // R6 sign-extended immediates, R1 rt placement
        drive("R6 addi",  imf(6'h09,1,12,16'hFFFF), 32'h1000, 32'd10, 32'h0, 1, 12, 32'd9, 32'h1004, 0, 0);
        drive("R6 lti",   imf(6'h0a,1,12,16'hFFFF), 32'h1000, 32'hFFFFFFFE, 32'h0, 1, 12, 32'h1, 32'h1004, 0, 0);
        drive("R6 ltiu",  imf(6'h0b,1,12,16'hFFFF), 32'h1000, 32'd5, 32'h0, 1, 12, 32'h1, 32'h1004, 0, 0);
        // R7 zero-extended immediates and upper load
        drive("R7 andi", imf(6'h0c,1,13,16'h8001), 32'h1000, 32'hFFFFFFFF, 0, 1, 13, 32'h00008001, 32'h1004, 0, 0);
        drive("R7 ori",  imf(6'h0d,1,13,16'hFFFF), 32'h1000, 32'h0, 0, 1, 13, 32'h0000FFFF, 32'h1004, 0, 0);
        drive("R7 xori", imf(6'h0e,1,13,16'hFFFF), 32'h1000, 32'hFFFF0000, 0, 1, 13, 32'hFFFFFFFF, 32'h1004, 0, 0);
        drive("R7 upper", imf(6'h0f,0,13,16'hABCD), 32'h1000, 32'h12345678, 0, 1, 13, 32'hABCD0000, 32'h1004, 0, 0);
        // R8 absolute jumps; region bits from PC+4
        drive("R8 jump region", jf(6'h02,26'h10), 32'h0FFFFFFC, 0, 0, 0, 0, 0, 32'h10000040, 0, 0);
        drive("R8 jump max", jf(6'h02,26'h3FFFFFF), 32'hF0001000, 0, 0, 0, 0, 0, 32'hFFFFFFFC, 0, 0);
        drive("R8 jump link", jf(6'h03,26'h500), 32'h1000, 0, 0, 1, 31, 32'h1004, 32'h1400, 0, 0);
        // R9 register jumps
        drive("R9 jreg", rf(6,0,0,0,6'h08), 32'h1000, 32'h2000, 0, 0, 0, 0, 32'h2000, 0, 0);
        drive("R9 jreg link alias", rf(5,0,5,0,6'h09), 32'h1008, 32'h3000, 0, 1, 5, 32'h100C, 32'h3000, 0, 0);
        drive("R11 jreg link r0", rf(5,0,0,0,6'h09), 32'h1008, 32'h3000, 0, 0, 0, 0, 32'h3000, 0, 0);
        // R10 branches
        drive("R10 beq taken back", imf(6'h04,1,2,16'hFFFE), 32'h1010, 32'h7, 32'h7, 0, 0, 0, 32'h100C, 0, 0);
        drive("R10 beq not taken",  imf(6'h04,1,2,16'hFFFE), 32'h1010, 32'h7, 32'h8, 0, 0, 0, 32'h1014, 0, 0);
        drive("R10 bne taken",      imf(6'h05,1,2,16'h0003), 32'h1000, 32'h7, 32'h8, 0, 0, 0, 32'h1010, 0, 0);
        drive("R10 bne not taken",  imf(6'h05,1,2,16'h0003), 32'h1000, 32'h7, 32'h7, 0, 0, 0, 32'h1004, 0, 0);
        // R11 register 0 destination
        drive("R11 add to r0", rf(1,2,0,0,6'h21), 32'h1000, 32'h5, 32'h6, 0, 0, 0, 32'h1004, 0, 0);
        drive("R11 addi to r0", imf(6'h09,1,0,16'h0001), 32'h1000, 32'h5, 0, 0, 0, 0, 32'h1004, 0, 0);
        // R12 hand-off group
        drive("R12 load word", imf(6'h23,1,4,16'h0010), 32'h1000, 32'h2000, 0, 0, 0, 0, 32'h1004, 0, 1);
        drive("R12 store byte", imf(6'h28,1,4,16'h0010), 32'h1000, 32'h2000, 0, 0, 0, 0, 32'h1004, 0, 1);
        drive("R12 mult", rf(1,2,0,0,6'h18), 32'h1000, 32'h3, 32'h4, 0, 0, 0, 32'h1004, 0, 1);
        drive("R12 syscall", rf(0,0,0,0,6'h0c), 32'h1000, 0, 0, 0, 0, 0, 32'h1004, 0, 1);
        drive("R12 move low", rf(0,0,8,0,6'h12), 32'h1000, 0, 0, 0, 0, 0, 32'h1004, 0, 1);
        // R13 illegal encodings and misaligned register jump
        drive("R13 bad opcode", 32'hFC000000, 32'h1000, 0, 0, 0, 0, 0, 32'h1000, 1, 0);
        drive("R13 bad funct", rf(1,2,3,0,6'h01), 32'h1020, 32'h1, 32'h1, 0, 0, 0, 32'h1020, 1, 0);
        drive("R13 misaligned jreg", rf(5,0,7,0,6'h09), 32'h1040, 32'h2002, 0, 0, 0, 0, 32'h1040, 1, 0);
        // R14 sequential step from another address
        drive("R14 step", rf(1,2,3,0,6'h25), 32'h0000ABC0, 32'h1, 32'h2, 1, 3, 32'h3, 32'h0000ABC4, 0, 0);
        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule